// File: doc/BRIEF.md
# Multi-Domain Power Sequencing Controller

This block switches a set of independent power domains on and off under software control. Every domain owns a bank of 32-bit word registers on a simple memory-mapped bus. Banks repeat at a fixed stride of 0x80 bytes, so domain n starts at n × 0x80. Software writes a command word naming the state it wants. A per-domain sequencer then steps that domain's power switch, isolation gate, clock enable and reset outputs in a fixed order. Programmable delay counters separate the steps.

A status word reports a 2-bit current-state field, a busy flag and a sticky completion flag. Software polls until busy drops and the completion flag rises. It then writes the status value it just read back to the same address, which clears the flag. The domains share only the bus decode, so all of them may sequence at the same time.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After reset every domain reports off: status reads 0x0002_0000 (state field bits 17:16 = 2, busy bit 3 = 0, completion bit 1 = 0), gate status reads 0x4, and the domain outputs are reset asserted (low), clock disabled, isolation active and power switch open.
- R2: Domain n's bank starts at byte n × 0x80. The switch delay (+0x14), off delay (+0x18) and on delay (+0x1C) read back the low DLY_W bits of the value written. The offsets 0x28, 0x2C and 0x38 to 0x7C, addresses past the last bank and byte addresses that are not word aligned read zero and ignore writes.
- R3: Writing 1 to the command word (+0x20) of an off domain runs the on sequence. Counting from the edge that accepts the write, the switch closes at edge 1, isolation releases at edge 3+Ds, the clock enables at edge 5+Ds+Don and reset deasserts at edge 6+Ds+Don. Ds and Don are the switch and on delays.
- R4: Writing 2 to the command word of an on domain runs the off sequence. Reset asserts at edge 1, the clock gates at edge 2, isolation engages at edge 3 and the switch opens at edge 5+Doff, where Doff is the off delay.
- R5: Busy (status bit 3) reads 1 from the accepting edge until the final step of the sequence. While busy is set, the state field keeps the old state. At the final step the field shows the new state (1 = on, 2 = off) and the completion flag (bit 1) sets.
- R6: The completion flag stays set until a write to the status word (+0x24) has bit 1 set. A write with bit 1 clear leaves the flag set, and writing back the value just read clears it.
- R7: A command written while busy is set is ignored. The running sequence keeps its timing and ends in the state it was started for.
- R8: A command for the state already reached sets the completion flag at the accepting edge, never sets busy and leaves the outputs unchanged. Command values other than 1 and 2 have no effect.
- R9: Gate status (+0x30) shows bit 0 = reset deasserted, bit 1 = clock enabled and bit 2 = isolation active. Switch status (+0x34) bit 0 shows the switch closed. The read-only words at +0x00, +0x04, +0x08, +0x0C and +0x10 show in bit 0, in that order: reset deasserted, clock enabled, isolation active, switch closed and switch open.
- R10: A command to one domain changes no output of any other domain.
- R11: Each domain keeps the nesting: reset deasserted implies clock enabled, clock enabled implies isolation released, and isolation released implies switch closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| dom_rst_n | output | NUM_DOM | Per-domain reset, low = asserted |
| dom_clk_en | output | NUM_DOM | Per-domain clock enable |
| dom_iso | output | NUM_DOM | Per-domain isolation (power-off gate), high = isolating |
| dom_psw_on | output | NUM_DOM | Per-domain power switch, high = closed |

## Verification
The ordering assertions assume each bus access lasts one cycle and that bus inputs are known whenever bus_sel is high. They also assume reset is applied before the first access, so every domain starts from the nested off state. The bench changes bus signals only on the falling clock edge and holds a write for exactly one rising edge. It draws random delays of 0 to 15 and uses random domain choices. A stray command is placed in mid-sequence only where the sequence is known to still be busy.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;
  localparam int BANK_SHIFT = 7;

  localparam logic [4:0] W_RST_RD   = 5'd0;
  localparam logic [4:0] W_CLK_RD   = 5'd1;
  localparam logic [4:0] W_ISO_RD   = 5'd2;
  localparam logic [4:0] W_SWON_RD  = 5'd3;
  localparam logic [4:0] W_SWOFF_RD = 5'd4;
  localparam logic [4:0] W_DLY_SW   = 5'd5;
  localparam logic [4:0] W_DLY_OFF  = 5'd6;
  localparam logic [4:0] W_DLY_ON   = 5'd7;
  localparam logic [4:0] W_CMD      = 5'd8;
  localparam logic [4:0] W_STAT     = 5'd9;
  localparam logic [4:0] W_GATE     = 5'd12;
  localparam logic [4:0] W_SWST     = 5'd13;

  localparam logic [1:0] ST_ON  = 2'd1;
  localparam logic [1:0] ST_OFF = 2'd2;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_ON_SW,
    SQ_ON_WSW,
    SQ_ON_ISO,
    SQ_ON_WON,
    SQ_ON_CLK,
    SQ_ON_RST,
    SQ_OFF_RST,
    SQ_OFF_CLK,
    SQ_OFF_ISO,
    SQ_OFF_WAIT,
    SQ_OFF_SW
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_rst_sync.sv
module pwr_seq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/pwr_seq_timer.sv
module pwr_seq_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         dec,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  always_comb begin
    cnt_en = load | (dec & (cnt_q != '0));
    cnt_d  = load ? load_val : cnt_q - W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/pwr_seq_decode.sv
module pwr_seq_decode #(
  parameter int NUM_DOM = 3,
  parameter int ADDR_W  = 9
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_DOM-1:0] sel,
  output logic [4:0]         word
);
  localparam int BS   = pwr_seq_pkg::BANK_SHIFT;
  localparam int BI_W = ADDR_W - BS;

  assign word = addr[BS-1:2];

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_sel
    assign sel[i] = (addr[1:0] == 2'b00) && (addr[ADDR_W-1:BS] == BI_W'(i));
  end
endmodule

// File: rtl/pwr_seq_domain.sv
module pwr_seq_domain
  import pwr_seq_pkg::*;
#(
  parameter int DLY_W = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  word,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic        pd_rst_n,
  output logic        pd_clk_en,
  output logic        pd_iso,
  output logic        pd_psw_on
);
  seq_state_e       fsm_q, fsm_d;
  logic [1:0]       pst_q, pst_d;
  logic             done_q, done_d;
  logic             rst_q, rst_d, clk_q, clk_d, iso_q, iso_d, sw_q, sw_d;
  logic [DLY_W-1:0] dsw_q, doff_q, don_q;
  logic             dsw_en, doff_en, don_en;
  logic             tmr_load, tmr_dec, tmr_zero;
  logic [DLY_W-1:0] tmr_val;
  logic             cmd_on, cmd_off, stat_clr, busy, fin, same_fin;

  assign busy     = (fsm_q != SQ_IDLE);
  assign cmd_on   = wr_en && (word == W_CMD) && (wdata == 32'(ST_ON));
  assign cmd_off  = wr_en && (word == W_CMD) && (wdata == 32'(ST_OFF));
  assign stat_clr = wr_en && (word == W_STAT) && wdata[1];
  assign dsw_en   = wr_en && (word == W_DLY_SW);
  assign doff_en  = wr_en && (word == W_DLY_OFF);
  assign don_en   = wr_en && (word == W_DLY_ON);

  pwr_seq_timer #(.W(DLY_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .dec      (tmr_dec),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  always_comb begin
    fsm_d    = fsm_q;
    pst_d    = pst_q;
    rst_d    = rst_q;
    clk_d    = clk_q;
    iso_d    = iso_q;
    sw_d     = sw_q;
    tmr_load = 1'b0;
    tmr_dec  = 1'b0;
    tmr_val  = dsw_q;
    fin      = 1'b0;
    same_fin = 1'b0;
    case (fsm_q)
      SQ_IDLE: begin
        if (cmd_on) begin
          if (pst_q == ST_ON) same_fin = 1'b1;
          else                fsm_d    = SQ_ON_SW;
        end else if (cmd_off) begin
          if (pst_q == ST_OFF) same_fin = 1'b1;
          else                 fsm_d    = SQ_OFF_RST;
        end
      end
      SQ_ON_SW: begin
        sw_d     = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = dsw_q;
        fsm_d    = SQ_ON_WSW;
      end
      SQ_ON_WSW: begin
        if (tmr_zero) fsm_d   = SQ_ON_ISO;
        else          tmr_dec = 1'b1;
      end
      SQ_ON_ISO: begin
        iso_d    = 1'b0;
        tmr_load = 1'b1;
        tmr_val  = don_q;
        fsm_d    = SQ_ON_WON;
      end
      SQ_ON_WON: begin
        if (tmr_zero) fsm_d   = SQ_ON_CLK;
        else          tmr_dec = 1'b1;
      end
      SQ_ON_CLK: begin
        clk_d = 1'b1;
        fsm_d = SQ_ON_RST;
      end
      SQ_ON_RST: begin
        rst_d = 1'b1;
        pst_d = ST_ON;
        fin   = 1'b1;
        fsm_d = SQ_IDLE;
      end
      SQ_OFF_RST: begin
        rst_d = 1'b0;
        fsm_d = SQ_OFF_CLK;
      end
      SQ_OFF_CLK: begin
        clk_d = 1'b0;
        fsm_d = SQ_OFF_ISO;
      end
      SQ_OFF_ISO: begin
        iso_d    = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = doff_q;
        fsm_d    = SQ_OFF_WAIT;
      end
      SQ_OFF_WAIT: begin
        if (tmr_zero) fsm_d   = SQ_OFF_SW;
        else          tmr_dec = 1'b1;
      end
      SQ_OFF_SW: begin
        sw_d  = 1'b0;
        pst_d = ST_OFF;
        fin   = 1'b1;
        fsm_d = SQ_IDLE;
      end
      default: fsm_d = SQ_IDLE;
    endcase
    done_d = done_q;
    if (stat_clr)        done_d = 1'b0;
    if (fin || same_fin) done_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q  <= SQ_IDLE;
      pst_q  <= ST_OFF;
      done_q <= 1'b0;
      rst_q  <= 1'b0;
      clk_q  <= 1'b0;
      iso_q  <= 1'b1;
      sw_q   <= 1'b0;
    end else begin
      fsm_q  <= fsm_d;
      pst_q  <= pst_d;
      done_q <= done_d;
      rst_q  <= rst_d;
      clk_q  <= clk_d;
      iso_q  <= iso_d;
      sw_q   <= sw_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dsw_q  <= '0;
      doff_q <= '0;
      don_q  <= '0;
    end else begin
      if (dsw_en)  dsw_q  <= wdata[DLY_W-1:0];
      if (doff_en) doff_q <= wdata[DLY_W-1:0];
      if (don_en)  don_q  <= wdata[DLY_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (word)
      W_RST_RD:   rdata[0] = rst_q;
      W_CLK_RD:   rdata[0] = clk_q;
      W_ISO_RD:   rdata[0] = iso_q;
      W_SWON_RD:  rdata[0] = sw_q;
      W_SWOFF_RD: rdata[0] = ~sw_q;
      W_DLY_SW:   rdata[DLY_W-1:0] = dsw_q;
      W_DLY_OFF:  rdata[DLY_W-1:0] = doff_q;
      W_DLY_ON:   rdata[DLY_W-1:0] = don_q;
      W_STAT:     rdata = {14'b0, pst_q, 12'b0, busy, 1'b0, done_q, 1'b0};
      W_GATE:     rdata[2:0] = {iso_q, clk_q, rst_q};
      W_SWST:     rdata[0] = sw_q;
      default:    rdata = '0;
    endcase
  end

  assign pd_rst_n  = rst_q;
  assign pd_clk_en = clk_q;
  assign pd_iso    = iso_q;
  assign pd_psw_on = sw_q;
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl #(
  parameter int NUM_DOM = 3,
  parameter int DLY_W   = 16,
  parameter int ADDR_W  = 9
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic [NUM_DOM-1:0] dom_rst_n,
  output logic [NUM_DOM-1:0] dom_clk_en,
  output logic [NUM_DOM-1:0] dom_iso,
  output logic [NUM_DOM-1:0] dom_psw_on
);
  logic               rst_int_n;
  logic [NUM_DOM-1:0] dsel;
  logic [4:0]         word;
  logic [31:0]        drd [NUM_DOM];

  pwr_seq_rst_sync u_rsync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  pwr_seq_decode #(.NUM_DOM(NUM_DOM), .ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (dsel),
    .word (word)
  );

  for (genvar i = 0; i < NUM_DOM; i++) begin : g_dom
    pwr_seq_domain #(.DLY_W(DLY_W)) u_dom (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .wr_en     (bus_sel & bus_we & dsel[i]),
      .word      (word),
      .wdata     (bus_wdata),
      .rdata     (drd[i]),
      .pd_rst_n  (dom_rst_n[i]),
      .pd_clk_en (dom_clk_en[i]),
      .pd_iso    (dom_iso[i]),
      .pd_psw_on (dom_psw_on[i])
    );
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_DOM; i++) begin
      if (bus_sel && dsel[i]) bus_rdata = bus_rdata | drd[i];
    end
  end
endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
  parameter int NUM_DOM = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_DOM-1:0] dom_rst_n,
  input logic [NUM_DOM-1:0] dom_clk_en,
  input logic [NUM_DOM-1:0] dom_iso,
  input logic [NUM_DOM-1:0] dom_psw_on
);
  for (genvar i = 0; i < NUM_DOM; i++) begin : g_chk
    // R11
    rst_needs_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dom_rst_n[i] |-> dom_clk_en[i]);
    // R11
    clk_needs_open_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dom_clk_en[i] |-> !dom_iso[i]);
    // R11
    iso_open_needs_sw_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dom_iso[i] |-> dom_psw_on[i]);
    // R3
    rst_release_after_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_rst_n[i]) |-> $past(dom_clk_en[i]));
    // R4
    sw_open_after_iso_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(dom_psw_on[i]) |-> $past(dom_iso[i]));
  end
endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NUM_DOM(NUM_DOM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dom_rst_n  (dom_rst_n),
  .dom_clk_en (dom_clk_en),
  .dom_iso    (dom_iso),
  .dom_psw_on (dom_psw_on)
);

// File: tb/tb_pwr_seq_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_seq_ctrl;
  localparam int ND = 3;
  localparam int AW = 9;

  logic          clk;
  logic          rst_n;
  logic          bus_sel;
  logic          bus_we;
  logic [AW-1:0] bus_addr;
  logic [31:0]   bus_wdata;
  logic [31:0]   bus_rdata;
  logic [ND-1:0] dom_rst_n, dom_clk_en, dom_iso, dom_psw_on;

  int n_chk = 0;
  int n_bad = 0;
  int dsw [ND];
  int doff[ND];
  int don [ND];
  int cur [ND];
  int seed_val;

  pwr_seq_ctrl #(.NUM_DOM(ND), .DLY_W(16), .ADDR_W(AW)) dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .dom_rst_n  (dom_rst_n),
    .dom_clk_en (dom_clk_en),
    .dom_iso    (dom_iso),
    .dom_psw_on (dom_psw_on)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [AW-1:0] adr(input int d, input int off);
    return AW'(d * 128 + off);
  endfunction

  function automatic logic [11:0] outs();
    return {dom_rst_n, dom_clk_en, dom_iso, dom_psw_on};
  endfunction

  function automatic logic [11:0] dmask(input int d);
    logic [11:0] m;
    m = '0;
    for (int g = 0; g < 4; g++) m[g*ND + d] = 1'b1;
    return m;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bw(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic br(input logic [AW-1:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_dly(input int d, input int s, input int of, input int on);
    dsw[d] = s; doff[d] = of; don[d] = on;
    bw(adr(d, 'h14), 32'(s));
    bw(adr(d, 'h18), 32'(of));
    bw(adr(d, 'h1C), 32'(on));
  endtask

  task automatic run_seq(input int d, input int cmd, input bit inj);
    int e1, e2, e3, e4;
    int f1 = -1, f2 = -1, f3 = -1, f4 = -1, fend = -1;
    logic [31:0] st;
    logic [11:0] snap, m;
    m = dmask(d);
    if (cmd == 1) begin
      e1 = 1; e2 = 3 + dsw[d]; e3 = 5 + dsw[d] + don[d]; e4 = 6 + dsw[d] + don[d];
    end else begin
      e1 = 1; e2 = 2; e3 = 3; e4 = 5 + doff[d];
    end
    snap = outs();
    bw(adr(d, 'h20), 32'(cmd));
    for (int k = 0; k < 2000; k++) begin
      bus_sel = 1'b0; bus_we = 1'b0;
      br(adr(d, 'h24), st);
      if (k == 0) begin
        chk("R5 busy set at accept", {31'b0, st[3]}, 32'd1);
        chk("R5 state kept while busy", {30'b0, st[17:16]}, 32'(cur[d]));
      end
      if (cmd == 1) begin
        if (f1 < 0 && dom_psw_on[d])  f1 = k;
        if (f2 < 0 && !dom_iso[d])    f2 = k;
        if (f3 < 0 && dom_clk_en[d])  f3 = k;
        if (f4 < 0 && dom_rst_n[d])   f4 = k;
      end else begin
        if (f1 < 0 && !dom_rst_n[d])  f1 = k;
        if (f2 < 0 && !dom_clk_en[d]) f2 = k;
        if (f3 < 0 && dom_iso[d])     f3 = k;
        if (f4 < 0 && !dom_psw_on[d]) f4 = k;
      end
      if (!st[3]) begin
        fend = k;
        break;
      end
      if (inj && k == 2) begin
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = adr(d, 'h20); bus_wdata = 32'(3 - cmd);
      end
      @(negedge clk);
    end
    if (cmd == 1) begin
      chk("R3 switch close edge",   32'(f1), 32'(e1));
      chk("R3 isolation release edge", 32'(f2), 32'(e2));
      chk("R3 clock enable edge",   32'(f3), 32'(e3));
      chk("R3 reset release edge",  32'(f4), 32'(e4));
    end else begin
      chk("R4 reset assert edge",   32'(f1), 32'(e1));
      chk("R4 clock gate edge",     32'(f2), 32'(e2));
      chk("R4 isolation edge",      32'(f3), 32'(e3));
      chk("R4 switch open edge",    32'(f4), 32'(e4));
    end
    chk(inj ? "R7 busy end with stray command" : "R5 busy end", 32'(fend), 32'(e4));
    chk(inj ? "R7 final state unchanged by stray" : "R5 new state", {30'b0, st[17:16]}, 32'(cmd));
    chk("R5 completion flag set", {31'b0, st[1]}, 32'd1);
    chk("R10 other domains untouched", 32'(outs() & ~m), 32'(snap & ~m));
    cur[d] = cmd;
    bw(adr(d, 'h24), st);
    br(adr(d, 'h24), st);
    chk("R6 write-back clears flag", {31'b0, st[1]}, 32'd0);
  endtask

  initial begin
    logic [31:0] rd;
    logic [11:0] snap;
    bus_sel = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    seed_val = $urandom(32'h5eed);
    for (int d = 0; d < ND; d++) begin
      cur[d] = 2; dsw[d] = 0; doff[d] = 0; don[d] = 0;
    end
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int d = 0; d < ND; d++) begin
      br(adr(d, 'h24), rd); chk("R1 status", rd, 32'h0002_0000);
      br(adr(d, 'h30), rd); chk("R1 gate status", rd, 32'h4);
    end
    chk("R1 outputs", 32'(outs()), {20'b0, 3'b000, 3'b000, 3'b111, 3'b000});

    // R2 map, delay width, unused offsets, out-of-range and misaligned
    bw(adr(1, 'h14), 32'hABCD_1234);
    br(adr(1, 'h14), rd); chk("R2 delay readback masked", rd, 32'h0000_1234);
    br(adr(0, 'h14), rd); chk("R2 bank stride isolation", rd, 32'h0);
    bw(adr(2, 'h2C), 32'hFFFF_FFFF);
    br(adr(2, 'h2C), rd); chk("R2 unused offset", rd, 32'h0);
    br(adr(2, 'h28), rd); chk("R2 unused offset 0x28", rd, 32'h0);
    bw(adr(1, 'h15), 32'h0000_0007);
    br(adr(1, 'h14), rd); chk("R2 misaligned write ignored", rd, 32'h0000_1234);
    bw(9'h180, 32'h5);
    br(9'h180, rd); chk("R2 beyond last bank", rd, 32'h0);
    snap = outs();
    bw(9'h1A0, 32'h1);
    repeat (4) @(negedge clk);
    chk("R2 command past last bank ignored", 32'(outs()), 32'(snap));

    // R8 same-state and invalid commands
    bw(adr(0, 'h20), 32'h2);
    br(adr(0, 'h24), rd); chk("R8 same state completes idle", rd, 32'h0002_0002);
    chk("R8 same state outputs", 32'(outs()), 32'(snap));
    // R6 a write without bit 1 keeps the flag, a write-back clears it
    bw(adr(0, 'h24), 32'h0000_0008);
    br(adr(0, 'h24), rd); chk("R6 flag survives bit1=0 write", rd, 32'h0002_0002);
    bw(adr(0, 'h24), rd);
    br(adr(0, 'h24), rd); chk("R6 flag cleared", rd, 32'h0002_0000);
    bw(adr(0, 'h20), 32'h3);
    repeat (3) @(negedge clk);
    br(adr(0, 'h24), rd); chk("R8 invalid command ignored", rd, 32'h0002_0000);
    chk("R8 invalid command outputs", 32'(outs()), 32'(snap));

    // Directed: zero delays, then nonzero
    set_dly(0, 0, 0, 0);
    run_seq(0, 1, 1'b0);
    // R9 readback while on
    br(adr(0, 'h30), rd); chk("R9 gate status on", rd, 32'h3);
    br(adr(0, 'h34), rd); chk("R9 switch status on", rd, 32'h1);
    br(adr(0, 'h00), rd); chk("R9 reset word on", rd, 32'h1);
    br(adr(0, 'h08), rd); chk("R9 iso word on", rd, 32'h0);
    br(adr(0, 'h10), rd); chk("R9 switch-open word on", rd, 32'h0);
    bw(adr(0, 'h20), 32'h1);
    br(adr(0, 'h24), rd); chk("R8 on-to-on completes idle", rd, 32'h0001_0002);
    bw(adr(0, 'h24), rd);
    set_dly(0, 3, 4, 2);
    run_seq(0, 2, 1'b1);
    br(adr(0, 'h30), rd); chk("R9 gate status off", rd, 32'h4);
    br(adr(0, 'h10), rd); chk("R9 switch-open word off", rd, 32'h1);
    br(adr(0, 'h0C), rd); chk("R9 switch-on word off", rd, 32'h0);
    set_dly(2, 7, 1, 5);
    run_seq(2, 1, 1'b1);

    // Random mix
    for (int it = 0; it < 30; it++) begin
      int d;
      d = int'($urandom % ND);
      set_dly(d, int'($urandom % 16), int'($urandom % 16), int'($urandom % 16));
      run_seq(d, (cur[d] == 1) ? 2 : 1, ($urandom % 4) == 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule